// File: doc/BRIEF.md
# Bus Role Address Decoder

Each device on a shared eight-bit instrument bus holds one copy of this block. A controller sends addressing bytes and universal commands while it holds the mode line low. The block watches every completed byte transfer. From those bytes it keeps two role flags: one says the device is an addressed listener, the other says it is the addressed talker. When a universal command arrives, the block also gives a one-cycle notice carrying the command's five-bit code. While the mode line is high, the bus carries free-form data, and the decoder leaves its state alone. A low level on the abort line drops the device out of both roles.

Bytes arrive as a one-directional stream. `rx_valid` marks the single cycle in which a completed transfer is presented on `rx_byte`. No ready signal exists and no back-pressure is possible. Every byte flagged valid is consumed in that same cycle. The upstream handshake must not present the next byte before the one-cycle decode has taken place. The command notice is also a plain stream with no ready: `ucmd_valid` is high for exactly one cycle, and `ucmd_code` is meaningful only in that cycle. All outputs are registered. They change at the clock edge that samples the byte.

Top module: `bus_role_decoder`

## Requirements
- R1: After reset, both role flags are low and `ucmd_valid` is low.
- R2: A byte presented with `rx_valid` high while `addr_mode_n` is high changes neither role flag and raises no command notice.
- R3: In a cycle with `rx_valid` low, the role flags keep their values and `ucmd_valid` is low at the next edge, whatever `rx_byte` and `addr_mode_n` hold.
- R4: In address mode the byte is split into three fields. Bits [6:5] hold the class: 00 is a universal command, 01 is a listen address, 10 is a talk address and 11 is reserved. Bits [4:0] hold the value. Bit [7] has no influence on any outcome.
- R5: A listen-class byte whose value equals `my_addr` (other than 31) sets `listen` at the next edge. It leaves `talk` unchanged. `listen` then stays set through any later bytes other than an unlisten byte or an abort.
- R6: The listen-class byte with value 31 (x0111111) clears `listen`. It never sets `listen`, so a device configured with address 31 never becomes a listener.
- R7: A talk-class byte whose value equals `my_addr` (other than 31) sets `talk` at the next edge and leaves `listen` unchanged.
- R8: A talk-class byte whose value is neither `my_addr` nor 31 clears `talk` and leaves `listen` unchanged.
- R9: The talk-class byte with value 31 (x1011111) clears `talk`. It never sets `talk`, so a device configured with address 31 never becomes the talker.
- R10: A universal-command byte raises `ucmd_valid` for exactly one cycle at the next edge, with `ucmd_code` equal to bits [4:0]. Both role flags keep their values.
- R11: With `abort_n` low at a clock edge, both role flags are low after that edge and `ucmd_valid` is low. This holds even if a byte is presented in the same cycle.
- R12: A reserved-class byte (bits [6:5] = 11) in address mode changes neither role flag and raises no command notice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle marker of a completed byte transfer |
| rx_byte | input | 8 | Received bus byte |
| addr_mode_n | input | 1 | Low selects address/command mode, high selects data mode |
| abort_n | input | 1 | Low forces the device out of all roles |
| my_addr | input | 5 | Configured device address |
| listen | output | 1 | Device is an addressed listener |
| talk | output | 1 | Device is the addressed talker |
| ucmd_valid | output | 1 | One-cycle universal-command notice |
| ucmd_code | output | 5 | Code of the universal command, valid with `ucmd_valid` |

## Verification
An abort and a valid address-mode byte can land in the same cycle. In that cycle the byte would set a flag or raise a notice, while the abort demands that everything be cleared. The bench provokes this by presenting each of the 256 byte values with `abort_n` low after first putting the device into both roles. It judges the result at the following falling edge: both flags must be low and no command notice may appear, regardless of the byte. The sweep also puts an own-talk byte and an own-listen byte on top of the opposite role, to show that each leaves the other flag untouched.

// File: rtl/adec_pkg.sv
package adec_pkg;

  typedef enum logic [1:0] {
    CLS_UCMD   = 2'b00,
    CLS_LISTEN = 2'b01,
    CLS_TALK   = 2'b10,
    CLS_RSVD   = 2'b11
  } byte_cls_e;

  typedef struct packed {
    logic listen_own;
    logic listen_clr;
    logic talk_own;
    logic talk_clr;
    logic ucmd;
  } dec_hits_t;

endpackage

// File: rtl/adec_classify.sv
module adec_classify
  import adec_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              take,
  input  logic [ADDR_W+1:0] fields,
  input  logic [ADDR_W-1:0] my_addr,
  output dec_hits_t         hits
);
  localparam logic [ADDR_W-1:0] RESERVED_VAL = {ADDR_W{1'b1}};

  byte_cls_e         cls;
  logic [ADDR_W-1:0] val;
  logic              is_rsv;
  logic              is_own;

  always_comb begin
    cls    = byte_cls_e'(fields[ADDR_W+1:ADDR_W]);
    val    = fields[ADDR_W-1:0];
    is_rsv = (val == RESERVED_VAL);
    is_own = (val == my_addr) && !is_rsv;
    hits   = '0;
    if (take) begin
      unique case (cls)
        CLS_UCMD:   hits.ucmd = 1'b1;
        CLS_LISTEN: begin
          hits.listen_clr = is_rsv;
          hits.listen_own = is_own;
        end
        CLS_TALK: begin
          hits.talk_own = is_own;
          hits.talk_clr = !is_own;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/adec_roles.sv
module adec_roles
  import adec_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      abort_n,
  input  dec_hits_t hits,
  output logic      listen,
  output logic      talk
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      listen <= 1'b0;
      talk   <= 1'b0;
    end else if (!abort_n) begin
      listen <= 1'b0;
      talk   <= 1'b0;
    end else begin
      if (hits.listen_own)      listen <= 1'b1;
      else if (hits.listen_clr) listen <= 1'b0;
      if (hits.talk_own)        talk   <= 1'b1;
      else if (hits.talk_clr)   talk   <= 1'b0;
    end
  end
endmodule

// File: rtl/adec_ucmd.sv
module adec_ucmd #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_n,
  input  logic              fire,
  input  logic [ADDR_W-1:0] code_in,
  output logic              ucmd_valid,
  output logic [ADDR_W-1:0] ucmd_code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ucmd_valid <= 1'b0;
      ucmd_code  <= '0;
    end else begin
      ucmd_valid <= fire && abort_n;
      if (fire && abort_n) ucmd_code <= code_in;
    end
  end
endmodule

// File: rtl/bus_role_decoder.sv
module bus_role_decoder
  import adec_pkg::*;
#(
  parameter int ADDR_W = 5,
  localparam int BYTE_W = ADDR_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              addr_mode_n,
  input  logic              abort_n,
  input  logic [ADDR_W-1:0] my_addr,
  output logic              listen,
  output logic              talk,
  output logic              ucmd_valid,
  output logic [ADDR_W-1:0] ucmd_code
);
  dec_hits_t hits;
  logic      take;
  logic      unused_msb;

  assign take       = rx_valid && !addr_mode_n;
  assign unused_msb = rx_byte[BYTE_W-1];

  adec_classify #(.ADDR_W(ADDR_W)) u_cls (
    .take    (take),
    .fields  (rx_byte[BYTE_W-2:0]),
    .my_addr (my_addr),
    .hits    (hits)
  );

  adec_roles u_roles (
    .clk     (clk),
    .rst_n   (rst_n),
    .abort_n (abort_n),
    .hits    (hits),
    .listen  (listen),
    .talk    (talk)
  );

  adec_ucmd #(.ADDR_W(ADDR_W)) u_ucmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort_n    (abort_n),
    .fire       (hits.ucmd),
    .code_in    (rx_byte[ADDR_W-1:0]),
    .ucmd_valid (ucmd_valid),
    .ucmd_code  (ucmd_code)
  );
endmodule

// File: rtl/adec_chk.sv
module adec_chk #(
  parameter int ADDR_W = 5,
  localparam int BYTE_W = ADDR_W + 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic [BYTE_W-1:0] rx_byte,
  input logic              addr_mode_n,
  input logic              abort_n,
  input logic [ADDR_W-1:0] my_addr,
  input logic              listen,
  input logic              talk,
  input logic              ucmd_valid,
  input logic [ADDR_W-1:0] ucmd_code
);
  localparam logic [ADDR_W-1:0] ONES = {ADDR_W{1'b1}};

  logic in_addr;
  assign in_addr = rx_valid && !addr_mode_n && abort_n;

  // R11
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_n |=> !listen && !talk && !ucmd_valid);

  // R2
  data_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && addr_mode_n && abort_n |=> $stable(listen) && $stable(talk) && !ucmd_valid);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid && abort_n |=> $stable(listen) && $stable(talk) && !ucmd_valid);

  // R6
  unlisten_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_addr && rx_byte[ADDR_W+1:0] == {2'b01, ONES} |=> !listen);

  // R5
  own_listen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_addr && rx_byte[ADDR_W+1:ADDR_W] == 2'b01 && rx_byte[ADDR_W-1:0] == my_addr
    && my_addr != ONES |=> listen && $stable(talk));

  // R7
  own_talk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_addr && rx_byte[ADDR_W+1:ADDR_W] == 2'b10 && rx_byte[ADDR_W-1:0] == my_addr
    && my_addr != ONES |=> talk && $stable(listen));

  // R8 R9
  other_talk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_addr && rx_byte[ADDR_W+1:ADDR_W] == 2'b10 && rx_byte[ADDR_W-1:0] != my_addr
    |=> !talk && $stable(listen));

  // R10
  ucmd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_addr && rx_byte[ADDR_W+1:ADDR_W] == 2'b00
    |=> ucmd_valid && ucmd_code == $past(rx_byte[ADDR_W-1:0]) && $stable(listen) && $stable(talk));

  // R10
  ucmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ucmd_valid |-> $past(in_addr));

  // R12
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_addr && rx_byte[ADDR_W+1:ADDR_W] == 2'b11
    |=> $stable(listen) && $stable(talk) && !ucmd_valid);
endmodule

bind bus_role_decoder adec_chk #(.ADDR_W(ADDR_W)) u_adec_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_valid    (rx_valid),
  .rx_byte     (rx_byte),
  .addr_mode_n (addr_mode_n),
  .abort_n     (abort_n),
  .my_addr     (my_addr),
  .listen      (listen),
  .talk        (talk),
  .ucmd_valid  (ucmd_valid),
  .ucmd_code   (ucmd_code)
);

// File: tb/test_bus_role_decoder.sv
module test_bus_role_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       addr_mode_n = 1'b1;
  logic       abort_n = 1'b1;
  logic [4:0] my_addr = '0;
  logic       listen, talk, ucmd_valid;
  logic [4:0] ucmd_code;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done = 1'b0;
  bit  exp_l = 1'b0, exp_t = 1'b0, exp_u = 1'b0;
  logic [4:0] exp_c = '0;

  always #10 clk = ~clk;

  bus_role_decoder i_bus_role_decoder (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .addr_mode_n(addr_mode_n), .abort_n(abort_n), .my_addr(my_addr),
    .listen(listen), .talk(talk), .ucmd_valid(ucmd_valid), .ucmd_code(ucmd_code)
  );

  task automatic compare(string req);
    n_cmp++;
    if (listen !== exp_l || talk !== exp_t || ucmd_valid !== exp_u ||
        (exp_u && ucmd_code !== exp_c)) begin
      n_bad++;
      $display("FAIL %s: got L=%0b T=%0b U=%0b C=%0d exp L=%0b T=%0b U=%0b C=%0d (addr=%0d byte=%02h)",
               req, listen, talk, ucmd_valid, ucmd_code, exp_l, exp_t, exp_u, exp_c,
               my_addr, rx_byte);
    end
  endtask

  // Called at a falling edge; presents one cycle of stimulus, checks at next falling edge.
  task automatic send(logic [7:0] b, bit v, bit mode_n, bit ab_n);
    string req;
    logic [1:0] cls;
    logic [4:0] val;
    cls = b[6:5];
    val = b[4:0];
    rx_byte = b; rx_valid = v; addr_mode_n = mode_n; abort_n = ab_n;
    exp_u = 1'b0;
    if (!ab_n) begin
      req = "R11"; exp_l = 1'b0; exp_t = 1'b0;
    end else if (!v) req = "R3";
    else if (mode_n) req = "R2";
    else begin
      case (cls)
        2'b00: begin req = "R10"; exp_u = 1'b1; exp_c = val; end
        2'b01: begin
          if (val == 5'd31) begin req = "R6"; exp_l = 1'b0; end
          else if (val == my_addr) begin req = "R5"; exp_l = 1'b1; end
          else req = "R4";
        end
        2'b10: begin
          if (val == 5'd31) begin req = "R9"; exp_t = 1'b0; end
          else if (val == my_addr) begin req = "R7"; exp_t = 1'b1; end
          else begin req = "R8"; exp_t = 1'b0; end
        end
        default: req = "R12";
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    compare(req);
    rx_valid = 1'b0; abort_n = 1'b1; addr_mode_n = 1'b1;
  endtask

  initial begin
    logic [4:0] addrs [5];
    addrs = '{5'd0, 5'd1, 5'd17, 5'd30, 5'd31};
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    for (int ai = 0; ai < 5; ai++) begin
      my_addr = addrs[ai];
      for (int st = 0; st < 4; st++) begin
        for (int b = 0; b < 256; b++) begin
          send(8'h00, 1'b1, 1'b0, 1'b0);
          if (st[0]) send({3'b001, my_addr}, 1'b1, 1'b0, 1'b1);
          if (st[1]) send({3'b010, my_addr}, 1'b1, 1'b0, 1'b1);
          send(8'(b), 1'b1, 1'b0, 1'b1);
          send(8'(b), 1'b0, 1'b0, 1'b1);
          send(8'(b ^ 8'h80), 1'b1, 1'b1, 1'b1);
          // R4: same byte with bit 7 flipped, must give the same outcome
          send(8'(b ^ 8'h80), 1'b1, 1'b0, 1'b1);
        end
      end
    end

    // R11: abort collides with every byte value while both roles are held
    my_addr = 5'd5;
    for (int b = 0; b < 256; b++) begin
      send({3'b001, my_addr}, 1'b1, 1'b0, 1'b1);
      send({3'b010, my_addr}, 1'b1, 1'b0, 1'b1);
      send(8'(b), 1'b1, 1'b0, 1'b0);
    end

    // R5: listen survives a run of data and foreign addresses
    send({3'b001, my_addr}, 1'b1, 1'b0, 1'b1);
    for (int k = 0; k < 31; k++) begin
      if (k != 5) send({3'b001, 5'(k)}, 1'b1, 1'b0, 1'b1);
      send(8'(k * 7), 1'b1, 1'b1, 1'b1);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule